// File: doc/BRIEF.md
# Burst-of-Four Synchronous SRAM with Separate Read and Write Ports

This block is a synthesizable model of a synchronous static memory with one read port and one write port, both running on the same clock. Every accepted request on either port moves a burst of four consecutive data words. The user gives only a burst index, which is the word address without its two low bits. The block produces those two bits itself, counting 0, 1, 2, 3 across the burst, so every burst starts on a four-word boundary. A memory of `4 << IDX_W` words is therefore reached through an index that is `IDX_W` bits wide.

A write request carries its first data beat in the same cycle. The next three beats follow on consecutive cycles. Each beat brings its own pair of byte-lane write enables, so the mask can change from beat to beat. A read request returns its four words through a two-stage pipeline: a registered memory read, then an output register. The words appear on consecutive cycles starting two cycles after acceptance, each one flagged by `rd_valid`.

Reads are coherent with writes that are still moving through the pipeline. Any write beat presented up to the cycle before a read word reaches the output is merged into that word, lane by lane. Each port takes a new request only once its current burst has finished. A request that arrives on a port in mid-burst is dropped.

Top module: `qburst_sram`

## Requirements
- R1: A read request accepted in cycle n drives `rd_valid` high in cycles n+2 to n+5. In those cycles `rd_data` carries the words at word addresses 4·idx+0, +1, +2, +3, in that order.
- R2: A write request accepted in cycle n writes the beats presented in cycles n, n+1, n+2 and n+3 to word addresses 4·idx+0, +1, +2 and +3.
- R3: For each write beat, `wr_be[i]` controls lane i, which is bits [9i+8:9i] of the word. Bit 0 controls bits 8:0 and bit 1 controls bits 17:9. A lane whose enable is low keeps its stored value.
- R4: A read request and a write request may be accepted in the same cycle, and both bursts proceed together.
- R5: A read word issued in cycle c reflects every write beat to the same word address presented in cycle c+1 or earlier. This holds whether the read starts in the same cycle as the write, one cycle before it, or one cycle after it.
- R6: Once a port accepts a request, it ignores requests in the following three cycles, whatever index they carry, and it can accept again in the fourth cycle. Back-to-back read bursts therefore give an unbroken run of valid words.
- R7: After reset, `rd_valid` is low and `rd_data` is zero. Memory contents start at zero.
- R8: `rd_data` is zero in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one data beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read burst request |
| rd_idx | input | IDX_W | Burst index for the read (word address without its two low bits) |
| wr_req | input | 1 | Write burst request; carries beat 0 |
| wr_idx | input | IDX_W | Burst index for the write |
| wr_data | input | DATA_W | Write data beat for the current cycle |
| wr_be | input | DATA_W/LANE_W | Per-lane write enables for the current beat |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for each read word on `rd_data` |

## Verification
The scoreboard first checks burst ordering with full-mask writes to many indices, read back with back-to-back read bursts. This separates correct low-bit generation from swapped or stuck beats and from gaps between bursts. Writes whose masks vary from beat to beat then tell per-beat mask sampling apart from a mask latched at request time, and lane 0 apart from lane 1. Reads overlapping writes to the same index at offsets of -1, 0, +1 and +2 cycles exercise each forwarding stage and the point where forwarding must stop. Requests with other indices injected in mid-burst show whether a busy port really drops them: a later read of those indices must still return zero.

// File: rtl/qb_pkg.sv
package qb_pkg;
  // Number of data beats per burst and width of the beat counter.
  localparam int BEAT_CNT = 4;
  localparam int BEAT_W   = $clog2(BEAT_CNT);
endpackage

// File: rtl/qb_burst_seq.sv
module qb_burst_seq
  import qb_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int ADDR_W = IDX_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [IDX_W-1:0]  idx,
  output logic              accept,
  output logic              active,
  output logic [ADDR_W-1:0] addr
);
  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  base;

  // Beat 0 is served in the accept cycle straight from the request index.
  assign accept = req & ~busy;
  assign active = accept | busy;
  assign addr   = busy ? {base, beat} : {idx, {BEAT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      beat <= '0;
      base <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      beat <= BEAT_W'(1);
      base <= idx;
    end else if (busy) begin
      beat <= beat + BEAT_W'(1);
      if (beat == BEAT_W'(BEAT_CNT - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/qb_lane_ram.sv
module qb_lane_ram #(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // Simple dual-port, read-first; forwarding is handled downstream.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qb_rd_pipe.sv
module qb_rd_pipe #(
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_fbe;
  logic [DATA_W-1:0] s1_fdata;
  logic              hit0;
  logic              hit1;
  logic [DATA_W-1:0] merged;

  // hit0: write in the same cycle the array is read (array returns old data).
  assign hit0 = rd_act && wr_act && (wr_addr == rd_addr);
  // hit1: write in the cycle the word sits in stage 1.
  assign hit1 = s1_v && wr_act && (wr_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_addr  <= '0;
      s1_fbe   <= '0;
      s1_fdata <= '0;
    end else begin
      s1_v     <= rd_act;
      s1_addr  <= rd_addr;
      s1_fbe   <= hit0 ? wr_be : '0;
      s1_fdata <= wr_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mid;
    assign mid = s1_fbe[i] ? s1_fdata[i*LANE_W +: LANE_W] : ram_q[i*LANE_W +: LANE_W];
    assign merged[i*LANE_W +: LANE_W] =
      (hit1 && wr_be[i]) ? wr_data[i*LANE_W +: LANE_W] : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= s1_v ? merged : '0;
      out_valid <= s1_v;
    end
  end
endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
  import qb_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  parameter int IDX_W  = 6,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int ADDR_W = IDX_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_req,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              rd_accept, rd_act;
  logic              wr_accept, wr_act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] ram_q;

  qb_burst_seq #(.IDX_W(IDX_W)) u_rd_seq (
    .clk(clk), .rst(rst), .req(rd_req), .idx(rd_idx),
    .accept(rd_accept), .active(rd_act), .addr(rd_addr)
  );

  qb_burst_seq #(.IDX_W(IDX_W)) u_wr_seq (
    .clk(clk), .rst(rst), .req(wr_req), .idx(wr_idx),
    .accept(wr_accept), .active(wr_act), .addr(wr_addr)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_ram
    qb_lane_ram #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk),
      .we(wr_act & wr_be[i]),
      .waddr(wr_addr),
      .wdata(wr_data[i*LANE_W +: LANE_W]),
      .raddr(rd_addr),
      .rdata(ram_q[i*LANE_W +: LANE_W])
    );
  end

  qb_rd_pipe #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst(rst),
    .rd_act(rd_act), .rd_addr(rd_addr),
    .wr_act(wr_act), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .ram_q(ram_q),
    .out_data(rd_data), .out_valid(rd_valid)
  );
endmodule

// File: rtl/qburst_sram_chk.sv
module qburst_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_accept,
  input logic              wr_accept
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (rd_valid) run_len <= run_len + 8'd1;
    else run_len <= '0;
  end

  p_rd_latency_r1: assert property (@(posedge clk) disable iff (rst)
    rd_accept |-> ##2 rd_valid);

  p_rd_run_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> (run_len[1:0] == 2'b00));

  p_rd_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    rd_accept |=> !rd_accept ##1 !rd_accept ##1 !rd_accept);

  p_wr_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !wr_accept ##1 !wr_accept ##1 !wr_accept);

  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> !rd_valid);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

bind qburst_sram qburst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_accept(rd_accept), .wr_accept(wr_accept)
);

// File: tb/tb_qburst_sram.sv
module tb_qburst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 18;
  localparam int LANE_W = 9;
  localparam int IDX_W  = 6;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int DEPTH  = 4 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_req = 1'b0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic              wr_req = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [LANES-1:0]  wr_be = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;

  qburst_sram #(.DATA_W(DATA_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_idx(rd_idx),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int addr; int cyc; string tag; } exp_t;
  exp_t exp_q[$];

  logic [DATA_W-1:0] ref_mem [DEPTH];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string phase_tag = "R1";

  initial for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] pat(input int idx, input int k, input int salt);
    return DATA_W'((idx * 131 + k * 17 + salt * 4099) ^ 18'h2A5A5);
  endfunction

  // Scoreboard monitor: compares each valid word against the reference memory.
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6: unexpected valid word actual=%h expected=no word", rd_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cyc != cyc || rd_data != ref_mem[e.addr]) begin
            errors++;
            $display("FAIL %s: addr %0d actual=%h@%0d expected=%h@%0d",
                     e.tag, e.addr, rd_data, cyc, ref_mem[e.addr], e.cyc);
          end
        end
      end else begin
        checks++;
        if (rd_data != '0) begin
          errors++;
          $display("FAIL R8: idle data actual=%h expected=0", rd_data);
        end
        if (exp_q.size() != 0 && exp_q[0].cyc <= cyc) begin
          errors++;
          $display("FAIL R1: missing word addr %0d actual=no valid expected=valid@%0d",
                   exp_q[0].addr, exp_q[0].cyc);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // Read burst driver; noise puts foreign requests on beats 1 and 2.
  task automatic rd_burst(input int idx, input bit noise);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin
        rd_req = 1'b1;
        rd_idx = IDX_W'(idx);
        for (int j = 0; j < 4; j++) begin
          exp_t e;
          e.addr = idx * 4 + j;
          e.cyc  = cyc + 2 + j;
          e.tag  = phase_tag;
          exp_q.push_back(e);
        end
      end else begin
        rd_req = noise && (k < 3);
        rd_idx = IDX_W'(idx ^ 21);
      end
    end
  endtask

  task automatic rd_idle();
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Write burst driver; bep holds two enable bits per beat, beat 0 lowest.
  task automatic wr_burst(input int idx, input int salt, input logic [7:0] bep,
                          input bit noise, input int noise_idx);
    for (int k = 0; k < 4; k++) begin
      logic [DATA_W-1:0] d;
      logic [LANES-1:0]  b;
      @(negedge clk);
      d = pat(idx, k, salt);
      b = bep[2*k +: 2];
      wr_data = d;
      wr_be   = b;
      if (k == 0) begin
        wr_req = 1'b1;
        wr_idx = IDX_W'(idx);
      end else begin
        wr_req = noise && (k < 3);
        wr_idx = IDX_W'(noise_idx);
      end
      @(posedge clk);
      for (int i = 0; i < LANES; i++)
        if (b[i]) ref_mem[idx*4+k][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    end
    @(negedge clk);
    wr_be = '0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R7: after reset actual=%b/%h expected=0/0", rd_valid, rd_data);
    end

    // R7: memory starts at zero.
    phase_tag = "R7";
    rd_burst(40, 1'b0);
    rd_idle();
    drain();

    // R2 then R1: full-mask writes, back-to-back reads (R6 continuous run).
    phase_tag = "R2";
    for (int i = 0; i < 8; i++) wr_burst(i, 1, 8'hFF, 1'b0, 0);
    phase_tag = "R1";
    for (int i = 0; i < 8; i++) rd_burst(i, 1'b0);
    rd_idle();
    drain();

    // R3: per-beat masks change each beat.
    phase_tag = "R3";
    wr_burst(3, 2, 8'b01_10_00_11, 1'b0, 0);
    wr_burst(6, 3, 8'b10_01_11_00, 1'b0, 0);
    rd_burst(3, 1'b0);
    rd_burst(6, 1'b0);
    rd_idle();
    drain();

    // R4: read and write accepted in the same cycle, different indices.
    phase_tag = "R4";
    fork
      wr_burst(9, 4, 8'hFF, 1'b0, 0);
      rd_burst(5, 1'b0);
    join
    rd_burst(9, 1'b0);
    rd_idle();
    drain();

    // R5: overlap offsets, read starts same cycle / one after / one before / two before.
    phase_tag = "R5";
    fork
      wr_burst(10, 5, 8'b11_01_10_11, 1'b0, 0);
      rd_burst(10, 1'b0);
    join
    rd_idle();
    drain();
    fork
      wr_burst(11, 6, 8'hFF, 1'b0, 0);
      begin @(negedge clk); rd_burst(11, 1'b0); end
    join
    rd_idle();
    drain();
    fork
      begin @(negedge clk); wr_burst(12, 7, 8'hFF, 1'b0, 0); end
      rd_burst(12, 1'b0);
    join
    rd_idle();
    drain();
    fork
      begin repeat (2) @(negedge clk); wr_burst(13, 8, 8'hFF, 1'b0, 0); end
      begin rd_burst(13, 1'b0); rd_idle(); end
    join
    drain();

    // R6: mid-burst requests ignored on both ports.
    phase_tag = "R6";
    wr_burst(14, 9, 8'hFF, 1'b1, 30);
    rd_burst(14, 1'b1);
    rd_burst(30, 1'b0);
    rd_idle();
    drain();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending words actual=%0d expected=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule